// File: doc/BRIEF.md
# Daisy-Chain Serial Peripheral Master

This block drives a chain of identical shift-register slaves that share one chip-select line. The master's data output feeds the data input of chain device 0. Each device passes its data output to the next device. The data output of device NUM_DEV-1 comes back to the master's data input. A single chip-select-low window carries one word for every device in the chain. When chip select returns high, each slave holds the word meant for it. The master at the same time has collected the word that each slave loaded when the window opened.

Software-side logic places transmit words in a flat parallel vector indexed by chain position. It pulses `start`, waits for `done`, and reads the received words back from the same positions. The block can optionally shift out one extra leading word. That word travels the whole chain and returns after the device words, and it is compared against what was sent as a continuity test of the loop. The serial clock runs in mode 0: it idles low, the master samples on the rising edge, data changes after the falling edge, and the most significant bit goes first. The clock is the system clock divided by an even parameter.

Top module: `chain_spi_master`

## Requirements
- R1: A `start` pulse while idle drives `cs_n` low and `busy` high on the next clock edge. `busy` stays high exactly while `cs_n` is low. A `start` pulse while busy is ignored and opens no second frame.
- R2: One frame holds exactly FRAME_WORDS×WORD_W rising serial-clock edges inside a single low period of `cs_n`. FRAME_WORDS is NUM_DEV+1 with the check word enabled and NUM_DEV without it.
- R3: The serial clock is low whenever `cs_n` is high. `mosi` never changes while `sck` is high. `miso` is sampled at the rising edge, and every word is sent and received most significant bit first.
- R4: Transmit word k sits at `tx_words[k*WORD_W +: WORD_W]`. The check word is sent first (when enabled), followed by words NUM_DEV-1 down to 0. At the end of the frame, chain device k therefore holds transmit word k.
- R5: `rx_words[k*WORD_W +: WORD_W]` holds the word that chain device k presented when `cs_n` fell. The first word to arrive comes from device NUM_DEV-1 and the last device word comes from device 0. The words are valid from `done` until the next accepted `start`.
- R6: With HALF = CLK_DIV/2 system cycles, the first rising edge of `sck` comes HALF cycles after `cs_n` falls. Successive `sck` edges are HALF cycles apart. `cs_n` rises HALF cycles after the last falling edge, so a frame keeps `cs_n` low for (2×FRAME_BITS+1)×HALF cycles.
- R7: `done` is high for exactly one cycle, in the cycle in which `cs_n` has just returned high and `busy` has dropped.
- R8: With the check word enabled, the word returned after the NUM_DEV device words is compared with the check word sent. A mismatch sets `check_err` at `done`. `check_err` is cleared when the next frame is accepted.
- R9: After reset, `cs_n` is 1 and `sck`, `busy`, `done` and `check_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one chain frame (accepted while idle) |
| tx_words | input | NUM_DEV*WORD_W | Transmit words, word k for chain device k |
| check_word | input | WORD_W | Leading loop-check word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_words | output | NUM_DEV*WORD_W | Received words, word k from chain device k |
| check_err | output | 1 | Returned check word differed from the one sent |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Shared chip select, active low |
| mosi | output | 1 | Serial data to chain device 0 |
| miso | input | 1 | Serial data from the last chain device |

## Verification
The bench builds the block with three devices of 4-bit words, a divider of 4 and the check word enabled, so one frame is 16 serial bits and 66 system cycles. With 4-bit words, every possible check word can be sent. The bench sweeps all sixteen, each with arithmetically varied transmit and response words for the three modelled slaves, and also runs all-zero and all-ones frames. The short frame makes it cheap to measure every edge spacing and to confirm where each word lands. A fault injected on the return line exercises the error flag and its clearing. A start pulse in mid-frame checks that a request arriving while busy is dropped.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } chain_state_e;
endpackage

// File: rtl/chain_spi_tick.sv
module chain_spi_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)      cnt_d = '0;
    else if (tick)  cnt_d = '0;
    else if (run)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
endmodule

// File: rtl/chain_spi_shreg.sv
module chain_spi_shreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             sample,
  input  logic             shift,
  input  logic             sdi,
  output logic [WIDTH-1:0] data,
  output logic             sdo
);
  logic [WIDTH-1:0] sr_q, sr_d;
  logic             bit_q, bit_d;

  always_comb begin
    sr_d  = sr_q;
    bit_d = bit_q;
    if (load)       sr_d = load_val;
    else if (shift) sr_d = {sr_q[WIDTH-2:0], bit_q};
    if (sample)     bit_d = sdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      bit_q <= bit_d;
    end
  end

  assign data = sr_q;
  assign sdo  = sr_q[WIDTH-1];

  assert_no_load_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && (shift || sample)));
endmodule

// File: rtl/chain_spi_master.sv
module chain_spi_master
  import chain_spi_pkg::*;
#(
  parameter int NUM_DEV  = 12,
  parameter int WORD_W   = 16,
  parameter int CLK_DIV  = 4,
  parameter bit CHECK_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_DEV*WORD_W-1:0] tx_words,
  input  logic [WORD_W-1:0]         check_word,
  output logic                      busy,
  output logic                      done,
  output logic [NUM_DEV*WORD_W-1:0] rx_words,
  output logic                      check_err,
  output logic                      sck,
  output logic                      cs_n,
  output logic                      mosi,
  input  logic                      miso
);
  localparam int HALF        = CLK_DIV / 2;
  localparam int DEV_BITS    = NUM_DEV * WORD_W;
  localparam int FRAME_WORDS = NUM_DEV + (CHECK_EN ? 1 : 0);
  localparam int FRAME_BITS  = FRAME_WORDS * WORD_W;
  localparam int CNT_W       = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  chain_state_e      state_q, state_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  bits_q, bits_d;
  logic              load, sample, shift, finish, tick;
  logic [FRAME_BITS-1:0] frame_val, frame_data;

  chain_spi_tick #(.HALF(HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q != ST_IDLE),
    .clear (load),
    .tick  (tick)
  );

  chain_spi_shreg #(.WIDTH(FRAME_BITS)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (frame_val),
    .sample   (sample),
    .shift    (shift),
    .sdi      (miso),
    .data     (frame_data),
    .sdo      (mosi)
  );

  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    bits_d  = bits_q;
    load    = 1'b0;
    sample  = 1'b0;
    shift   = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_LEAD;
        cs_n_d  = 1'b0;
        bits_d  = '0;
        load    = 1'b1;
      end
      ST_LEAD: if (tick) begin
        state_d = ST_SHIFT;
        sck_d   = 1'b1;
        sample  = 1'b1;
      end
      ST_SHIFT: if (tick) begin
        if (sck_q) begin
          sck_d  = 1'b0;
          shift  = 1'b1;
          bits_d = bits_q + 1'b1;
          if (bits_q == LAST_BIT) state_d = ST_TAIL;
        end else begin
          sck_d  = 1'b1;
          sample = 1'b1;
        end
      end
      ST_TAIL: if (tick) begin
        state_d = ST_IDLE;
        cs_n_d  = 1'b1;
        done_d  = 1'b1;
        finish  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      bits_q  <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      bits_q  <= bits_d;
    end
  end

  generate
    if (CHECK_EN) begin : g_check
      logic [WORD_W-1:0] chk_q;
      logic              err_q;
      assign frame_val = {check_word, tx_words};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chk_q <= '0;
          err_q <= 1'b0;
        end else begin
          if (load) chk_q <= check_word;
          if (load)        err_q <= 1'b0;
          else if (finish) err_q <= (frame_data[WORD_W-1:0] != chk_q);
        end
      end
      assign check_err = err_q;
    end else begin : g_nocheck
      assign frame_val = tx_words;
      assign check_err = 1'b0;
    end
  endgenerate

  assign rx_words = frame_data[FRAME_BITS-1 -: DEV_BITS];
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign sck      = sck_q;
  assign cs_n     = cs_n_q;

  assert_cs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy != cs_n);
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));
  assert_bit_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= CNT_W'(FRAME_BITS));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
endmodule

// File: tb/chain_spi_master_tb.sv
module chain_spi_master_tb_top;
  localparam int N     = 3;
  localparam int M     = 4;
  localparam int DIV   = 4;
  localparam int H     = DIV / 2;
  localparam int FBITS = (N + 1) * M;
  localparam int FLEN  = (2 * FBITS + 1) * H;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [N*M-1:0] tx_words;
  logic [M-1:0]   check_word;
  logic busy, done, check_err, sck, cs_n, mosi, miso;
  logic [N*M-1:0] rx_words;
  logic corrupt;

  always #10 clk = ~clk;

  chain_spi_master #(.NUM_DEV(N), .WORD_W(M), .CLK_DIV(DIV), .CHECK_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_words(tx_words),
    .check_word(check_word), .busy(busy), .done(done), .rx_words(rx_words),
    .check_err(check_err), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  // chain of slave shift registers, mode 0
  logic [M-1:0] resp_arr [N];
  logic [M-1:0] dev_sr   [N];
  logic [M-1:0] dev_cmd  [N];
  logic         dev_bit  [N];
  logic cs_prev = 1'b1;
  logic sck_prev = 1'b0;

  assign miso = dev_sr[N-1][M-1] ^ corrupt;

  always @(sck or cs_n) begin
    if (cs_n === 1'b0 && cs_prev === 1'b1) begin
      for (int k = 0; k < N; k++) dev_sr[k] = resp_arr[k];
    end else if (cs_n === 1'b1 && cs_prev === 1'b0) begin
      for (int k = 0; k < N; k++) dev_cmd[k] = dev_sr[k];
    end else if (cs_n === 1'b0 && sck === 1'b1 && sck_prev === 1'b0) begin
      for (int k = 0; k < N; k++) dev_bit[k] = (k == 0) ? mosi : dev_sr[k-1][M-1];
    end else if (cs_n === 1'b0 && sck === 1'b0 && sck_prev === 1'b1) begin
      for (int k = 0; k < N; k++) dev_sr[k] = {dev_sr[k][M-2:0], dev_bit[k]};
    end
    cs_prev  = cs_n;
    sck_prev = sck;
  end

  // edge monitor
  int cyc = 0, frames = 0, rises = 0, done_cnt = 0;
  int t_fall = 0, t_first = 0, t_last_fall = 0, t_rise = 0;
  int idle_sck_bad = 0, done_misplaced = 0;
  logic m_cs = 1'b1, m_sck = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!cs_n && m_cs) begin
        frames++; rises = 0; done_cnt = 0; t_fall = cyc;
      end
      if (cs_n && !m_cs) t_rise = cyc;
      if (!cs_n && sck && !m_sck) begin
        if (rises == 0) t_first = cyc;
        rises++;
      end
      if (!cs_n && !sck && m_sck) t_last_fall = cyc;
      if (cs_n && sck) idle_sck_bad++;
      if (done) begin
        done_cnt++;
        if (!(cs_n && !m_cs)) done_misplaced++;
      end
      m_cs = cs_n; m_sck = sck;
    end
  end

  int checks = 0, errors = 0;
  logic [M-1:0] tx_arr [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [M-1:0] cw, input bit bad, input bit poke);
    int f0, dc;
    for (int k = 0; k < N; k++) tx_words[k*M +: M] = tx_arr[k];
    check_word = cw;
    corrupt = bad;
    f0 = frames;
    dc = done_misplaced;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !cs_n, "R1 busy and cs_n after start", {busy, cs_n}, 2);
    chk(!check_err, "R8 check_err cleared on start", check_err, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(cs_n && !busy, "R7 done with cs_n high and idle", {cs_n, busy}, 2);
    repeat (3 * H) @(negedge clk);
    chk(frames == f0 + 1, "R1 one frame per accepted start", frames - f0, 1);
    chk(rises == FBITS, "R2 rising edges per frame", rises, FBITS);
    chk(t_first - t_fall == H, "R6 lead time", t_first - t_fall, H);
    chk(t_rise - t_last_fall == H, "R6 tail time", t_rise - t_last_fall, H);
    chk(t_rise - t_fall == FLEN, "R6 frame length", t_rise - t_fall, FLEN);
    chk(done_cnt == 1 && done_misplaced == dc, "R7 single done pulse", done_cnt, 1);
    chk(idle_sck_bad == 0, "R3 sck low while deselected", idle_sck_bad, 0);
    for (int k = 0; k < N; k++) begin
      chk(dev_cmd[k] == tx_arr[k], $sformatf("R4 device %0d command", k), dev_cmd[k], tx_arr[k]);
      if (!bad)
        chk(rx_words[k*M +: M] == resp_arr[k], $sformatf("R5 rx word %0d", k),
            rx_words[k*M +: M], resp_arr[k]);
    end
    chk(check_err == bad, "R8 loop check flag", check_err, bad);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; tx_words = '0; check_word = '0; corrupt = 1'b0;
    for (int k = 0; k < N; k++) begin resp_arr[k] = '0; tx_arr[k] = '0; end
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !busy && !done && !check_err, "R9 reset state",
        {cs_n, sck, busy, done, check_err}, 16);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && !sck && !busy && !done && !check_err, "R9 idle after reset release",
        {cs_n, sck, busy, done, check_err}, 16);
    // exhaustive sweep of the check word
    for (int f = 0; f < 16; f++) begin
      for (int k = 0; k < N; k++) begin
        tx_arr[k]   = M'(f * 3 + k * 5 + 1);
        resp_arr[k] = M'(~(f + k * 7));
      end
      run_frame(M'(f), 1'b0, 1'b0);
    end
    // all zeros and all ones
    for (int k = 0; k < N; k++) begin tx_arr[k] = '0; resp_arr[k] = '1; end
    run_frame('0, 1'b0, 1'b0);
    for (int k = 0; k < N; k++) begin tx_arr[k] = '1; resp_arr[k] = '0; end
    run_frame('1, 1'b0, 1'b0);
    // start while busy ignored (R1)
    for (int k = 0; k < N; k++) begin tx_arr[k] = M'(9 + k); resp_arr[k] = M'(2 * k + 3); end
    run_frame(4'hA, 1'b0, 1'b1);
    // broken return line sets the flag, next clean frame clears it (R8)
    run_frame(4'h5, 1'b1, 1'b0);
    run_frame(4'h6, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule